// File: doc/BRIEF.md
# Rewindable First-Word-Fall-Through FIFO

A single-clock FIFO whose head word is always visible on the read port: as soon as at least one word is held, `rd_valid` is high and `rd_data` carries that word without a preceding read request. Counting the word that presents on the output, the FIFO holds `DEPTH + 1` words (16 with defaults). Both data ports follow valid/ready rules. A write transfers on a rising edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` falls only when the FIFO is full. A read transfers on an edge where `rd_valid` and `rd_ready` are both high. Holding `rd_ready` low stalls the head word in place for as long as needed.

When rewind mode is latched during reset, a one-cycle pulse on `rt_req` rewinds the read side to the first word written after reset. On the very next cycle that word is on `rd_data` with `rd_valid` high, even if the FIFO had drained. Each further accepted read then returns the next word, one per cycle, with no extra latency. After the rewind, the occupancy becomes the number of words written since reset, and the three level flags are recomputed from that count. A rewind is refused when the mode is off, when fewer than two words have been written, or when so many were written that the first ones may have been overwritten. A refused rewind leaves the data path untouched and sets a sticky error bit.

Top module: `fifo_rt_fwft`

## Requirements
- R1: After reset the FIFO is empty: `rd_valid`=0, `wr_ready`=1, `almost_empty`=1, `half_full`=0, `almost_full`=0, `rt_err`=0.
- R2: Words leave in the order they were accepted. While `rd_valid` is high, `rd_data` shows the oldest held word without any read request. A read transfer (`rd_valid`&`rd_ready`) advances to the next word in the following cycle.
- R3: Capacity is `DEPTH+1` words. `wr_ready` is low exactly when that many are held, and a write offered while `wr_ready` is low is dropped.
- R4: An accepted rewind makes `rd_valid`=1 and `rd_data` equal to the first word written since reset in the next cycle, including when the FIFO was empty.
- R5: After a rewind, the words written since reset come out again in order, one per read transfer, starting the cycle after the rewind.
- R6: After a rewind, the occupancy equals the number of words written since reset, counting a write accepted in the same cycle. The flags follow that count.
- R7: A rewind accepted in a cycle where `rd_ready` is high consumes no word in that cycle.
- R8: A rewind is accepted only if rewind mode is latched and the number of words written since reset lies between 2 and `DEPTH-1` inclusive. Any other `rt_req` is ignored and sets `rt_err`, which stays high until reset.
- R9: `rt_mode` is latched while `rst_n` is low. Its value after reset has no effect until the next reset.
- R10: With `n` words held, `almost_empty` = (n <= `ae_level`), `half_full` = (n > (DEPTH+1)/2), and `almost_full` = (n >= DEPTH+1-`af_level`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_mode | input | 1 | Rewind enable, latched during reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | FIFO can take a word (not full) |
| wr_data | input | W | Write word |
| rd_valid | output | 1 | Head word present on `rd_data` |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_data | output | W | Head word |
| rt_req | input | 1 | Rewind request, one cycle |
| ae_level | input | CW | Almost-empty threshold |
| af_level | input | CW | Almost-full distance from capacity |
| almost_empty | output | 1 | Occupancy at or below `ae_level` |
| half_full | output | 1 | Occupancy above half capacity |
| almost_full | output | 1 | Occupancy within `af_level` of capacity |
| rt_err | output | 1 | Sticky: a rewind was refused |

## Verification
The bench rewinds a FIFO that has fully drained. A design that waits for an extra read there would leave `rd_valid` low or present stale data. It asserts `rd_ready` in the same cycle as the rewind, which catches a design that lets the read win and skips the first word. It also rewinds in a cycle with a concurrent write, where a wrong occupancy shows up as flags that are off by one. Refused rewinds are driven at zero and one written words, past the write limit, and with the mode latched off. A design that honours any of them shows a moved head word or an `rt_err` that stays low. Randomised traffic around the full and empty edges checks that a write at full is dropped.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_TAKE   = 2'd1,
    RT_REJECT = 2'd2
  } rt_kind_t;
endpackage

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int W  = 32,
  parameter int D  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [D];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int D  = 16,
  parameter int AW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rt_mode,
  input  logic          wr_valid,
  input  logic          rd_ready,
  input  logic          rt_req,
  output logic          wr_fire,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          rt_err
);
  localparam logic [CW-1:0] CAP     = CW'(D);
  localparam logic [CW-1:0] TOT_MAX = CW'(D - 1);
  localparam logic [CW-1:0] RT_LIM  = CW'(D - 2);
  localparam logic [AW-1:0] LAST    = AW'(D - 1);

  logic          mode_q;
  logic [CW-1:0] wr_total;
  logic          rd_fire;
  rt_kind_t      rt_kind;

  assign rd_valid = (count != '0);
  assign wr_ready = (count < CAP);
  assign wr_fire  = wr_valid & wr_ready;

  always_comb begin
    rt_kind = RT_NONE;
    if (rt_req) begin
      if (mode_q && wr_total >= CW'(2) && wr_total <= RT_LIM) rt_kind = RT_TAKE;
      else rt_kind = RT_REJECT;
    end
  end

  assign rd_fire = rd_ready & rd_valid & (rt_kind != RT_TAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= rt_mode;
      wr_total <= '0;
      waddr    <= '0;
      raddr    <= '0;
      count    <= '0;
      rt_err   <= 1'b0;
    end else begin
      if (wr_fire) begin
        waddr <= (waddr == LAST) ? '0 : waddr + AW'(1);
        if (wr_total != TOT_MAX) wr_total <= wr_total + CW'(1);
      end
      if (rt_kind == RT_TAKE) begin
        raddr <= '0;
        count <= wr_total + CW'(wr_fire);
      end else begin
        if (rd_fire) raddr <= (raddr == LAST) ? '0 : raddr + AW'(1);
        count <= count + CW'(wr_fire) - CW'(rd_fire);
      end
      if (rt_kind == RT_REJECT) rt_err <= 1'b1;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);

  // R4
  rt_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_kind == RT_TAKE) |=> (rd_valid && raddr == '0));

  // R8
  rt_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_err |=> rt_err);

  // R8
  rt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_kind == RT_REJECT) |=> rt_err);

  // R2
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !wr_fire && rt_kind == RT_NONE) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags #(
  parameter int D  = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] ae_level,
  input  logic [CW-1:0] af_level,
  output logic          almost_empty,
  output logic          half_full,
  output logic          almost_full
);
  localparam logic [CW:0]   CAP_X = (CW+1)'(D);
  localparam logic [CW-1:0] HALF  = CW'(D / 2);

  assign almost_empty = (count <= ae_level);
  assign half_full    = (count > HALF);
  assign almost_full  = ({1'b0, count} + {1'b0, af_level}) >= CAP_X;

  // R10
  hf_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_full |-> (count != '0));
endmodule

// File: rtl/fifo_rt_fwft.sv
module fifo_rt_fwft #(
  parameter int DEPTH = 15,
  parameter int W     = 32,
  parameter int D     = DEPTH + 1,
  parameter int AW    = (D > 1) ? $clog2(D) : 1,
  parameter int CW    = $clog2(D + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rt_mode,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [W-1:0]  wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [W-1:0]  rd_data,
  input  logic          rt_req,
  input  logic [CW-1:0] ae_level,
  input  logic [CW-1:0] af_level,
  output logic          almost_empty,
  output logic          half_full,
  output logic          almost_full,
  output logic          rt_err
);
  logic          wr_fire;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [CW-1:0] count;

  fifo_rt_ctrl #(.D(D), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rt_mode(rt_mode),
    .wr_valid(wr_valid), .rd_ready(rd_ready), .rt_req(rt_req),
    .wr_fire(wr_fire), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .waddr(waddr), .raddr(raddr), .count(count), .rt_err(rt_err)
  );

  fifo_rt_mem #(.W(W), .D(D), .AW(AW)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );

  fifo_rt_flags #(.D(D), .CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count),
    .ae_level(ae_level), .af_level(af_level),
    .almost_empty(almost_empty), .half_full(half_full), .almost_full(almost_full)
  );
endmodule

// File: tb/fifo_rt_fwft_tb.sv
`timescale 1ns/1ps
module fifo_rt_fwft_tb;
  localparam int DEPTH = 15;
  localparam int W     = 32;
  localparam int D     = DEPTH + 1;
  localparam int CW    = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rt_mode = 1'b1;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [W-1:0]  wr_data = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [W-1:0]  rd_data;
  logic          rt_req = 1'b0;
  logic [CW-1:0] ae_level = CW'(2);
  logic [CW-1:0] af_level = CW'(2);
  logic          almost_empty, half_full, almost_full, rt_err;

  always #4 clk = ~clk;

  fifo_rt_fwft #(.DEPTH(DEPTH), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rt_mode(rt_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rt_req(rt_req), .ae_level(ae_level), .af_level(af_level),
    .almost_empty(almost_empty), .half_full(half_full),
    .almost_full(almost_full), .rt_err(rt_err)
  );

  int vectors = 0;
  int miscompares = 0;
  int wi = 0, ri = 0;
  bit m_mode = 1'b1, m_err = 1'b0;
  logic [W-1:0] hist [D];
  string data_tag = "R2";

  function automatic int occ();
    return wi - ri;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    int n = occ();
    check("R2 rd_valid", W'(rd_valid), W'(n > 0));
    check("R3 wr_ready", W'(wr_ready), W'(n < D));
    if (n > 0) check({data_tag, " rd_data"}, rd_data, hist[ri % D]);
    check("R10 almost_empty", W'(almost_empty), W'(n <= int'(ae_level)));
    check("R10 half_full", W'(half_full), W'(n > D / 2));
    check("R10 almost_full", W'(almost_full), W'(n >= D - int'(af_level)));
    check("R8 rt_err", W'(rt_err), W'(m_err));
  endtask

  task automatic step(bit wv, logic [W-1:0] wd, bit rr, bit rt);
    bit wf, take, rf;
    int n = occ();
    wr_valid = wv; wr_data = wd; rd_ready = rr; rt_req = rt;
    wf   = wv && (n < D);
    take = rt && m_mode && (wi >= 2) && (wi <= D - 2);
    rf   = rr && (n > 0) && !take;
    @(posedge clk);
    if (wf) begin hist[wi % D] = wd; wi++; end
    if (take) ri = 0;
    else if (rf) ri++;
    if (rt && !take) m_err = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0; rt_req = 1'b0;
    check_all();
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rt_mode = mode;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wi = 0; ri = 0; m_err = 1'b0; m_mode = mode;
    rt_mode = ~mode;  // R9: value after reset must not matter
    check_all();
  endtask

  initial begin : watchdog
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    // R1: reset state
    do_reset(1'b1);
    check("R1 rd_valid", W'(rd_valid), '0);
    check("R1 wr_ready", W'(wr_ready), W'(1));
    check("R1 almost_empty", W'(almost_empty), W'(1));
    check("R1 rt_err", W'(rt_err), '0);

    // R8: rewind with no words and with one word is refused
    step(0, 0, 0, 1);
    check("R8 ignored rd_valid", W'(rd_valid), '0);
    do_reset(1'b1);
    step(1, 32'hAAAA_0001, 0, 0);
    step(0, 0, 0, 1);
    check("R8 one word err", W'(rt_err), W'(1));

    // R4 R5 R7: drain then rewind with rd_ready high in the same cycle
    do_reset(1'b1);
    step(1, 32'h1111_0001, 0, 0);
    step(1, 32'h1111_0002, 0, 0);
    step(1, 32'h1111_0003, 0, 0);
    for (int k = 0; k < 3; k++) step(0, 0, 1, 0);
    data_tag = "R4";
    step(0, 0, 1, 1);
    check("R4 head after rewind", rd_data, 32'h1111_0001);
    check("R7 no word consumed", W'(rd_valid), W'(1));
    data_tag = "R5";
    step(0, 0, 1, 0);
    check("R5 second word", rd_data, 32'h1111_0002);
    // R6: rewind with concurrent write, occupancy = writes since reset
    data_tag = "R6";
    step(1, 32'h1111_0004, 0, 1);
    check("R6 occupancy flag", W'(almost_empty), W'(0));
    data_tag = "R2";

    // R9: mode latched low, rewind refused
    do_reset(1'b0);
    step(1, 32'h2222_0001, 0, 0);
    step(1, 32'h2222_0002, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    check("R9 head unchanged", rd_data, 32'h2222_0002);

    // R3: fill to capacity, extra write dropped, late rewind refused (R8)
    do_reset(1'b1);
    for (int k = 0; k < D; k++) step(1, 32'h3300_0000 + k, 0, 0);
    check("R3 full", W'(wr_ready), '0);
    step(1, 32'hDEAD_BEEF, 0, 0);
    step(0, 0, 0, 1);
    check("R8 beyond limit", W'(rt_err), W'(1));
    for (int k = 0; k < D; k++) step(0, 0, 1, 0);

    // random episodes
    for (int e = 0; e < 24; e++) begin
      int wp = 20 + ($urandom % 70);
      int rp = 20 + ($urandom % 70);
      ae_level = CW'($urandom % (D + 1));
      af_level = CW'($urandom % (D + 1));
      do_reset(($urandom % 4) != 0);
      for (int c = 0; c < 300; c++)
        step(($urandom % 100) < wp, $urandom, ($urandom % 100) < rp,
             ($urandom % 12) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule